// File: doc/BRIEF.md
# Serial Port Control and Channel Mode Router

This block sits between a serial port's register file and its data paths. It holds the port's control word and mode word, works out from them whether the receive and transmit paths are open, and steers each byte to the right destination. Bytes come from the line deserializer (a one-cycle strobe with data) and from software writes to the data register. They leave as push strobes into the receive FIFO and toward the line transmitter. The serializer, the deserializer and both FIFOs live outside this block.

A two-bit channel mode field picks one of four routings. Normal mode keeps the two directions apart. Echo mode keeps the received byte for software and also sends it back out. Local loopback turns software writes around into the receive FIFO. Remote loopback returns line bytes to the line without software seeing them. Each path has its own enable bit and disable bit, and the disable bit wins. Two command bits in the control word flush the FIFOs with a one-cycle pulse and then clear themselves. A break request level is taken from a start bit and a stop bit.

Top module: `uart_mode_router`

## Requirements
- R1: After reset the control readback is 0x128, meaning receive disable (bit 3), transmit disable (bit 5) and stop break (bit 8) are set. Both enable outputs and the break request are low, the mode readback is 0 (normal), and no push or flush strobe is active.
- R2: Each path's enable output is high only when its enable bit is set and its disable bit is clear. Receive uses enable bit 2 and disable bit 3. Transmit uses enable bit 4 and disable bit 5. The outputs take the new value in the cycle after the control write.
- R3: A control write with bit 0 set raises the receive FIFO flush for exactly the one cycle after the write. Bit 1 does the same for the transmit FIFO flush. Bits 0 and 1 always read back as zero.
- R4: The break request is high exactly while control bit 7 (start break) is set and bit 8 (stop break) is clear.
- R5: The channel mode is mode-word bits 9:8: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. In normal mode, a line byte is pushed into the receive FIFO and a software byte is pushed toward the transmitter. Each push happens one cycle after its strobe and carries the same data.
- R6: In echo mode, a line byte is pushed both into the receive FIFO and toward the transmitter. A software byte is dropped.
- R7: In local loopback, a software byte is pushed into the receive FIFO. Line bytes are dropped and nothing goes toward the transmitter.
- R8: In remote loopback, a line byte is pushed toward the transmitter only. Software bytes are dropped and nothing enters the receive FIFO.
- R9: No push reaches a path whose enable output is low. This includes the receive FIFO in local loopback.
- R10: A byte strobe that arrives in the same cycle as a control write is routed with the enables that were in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | CTL_W (9) | Control word write data |
| mode_wr | input | 1 | Mode word write strobe |
| mode_wdata | input | MODE_W (10) | Mode word write data |
| line_rx_valid | input | 1 | Byte received from the line deserializer |
| line_rx_data | input | DATA_W (8) | Received byte |
| sw_tx_valid | input | 1 | Software write to the data register |
| sw_tx_data | input | DATA_W (8) | Software byte |
| rxq_push | output | 1 | Push into the receive FIFO |
| rxq_data | output | DATA_W (8) | Byte for the receive FIFO |
| txq_push | output | 1 | Push toward the line transmitter |
| txq_data | output | DATA_W (8) | Byte for the transmitter |
| rxq_flush | output | 1 | One-cycle receive FIFO reset |
| txq_flush | output | 1 | One-cycle transmit FIFO reset |
| brk_req | output | 1 | Break request level |
| rx_en | output | 1 | Receive path enabled |
| tx_en | output | 1 | Transmit path enabled |
| ctl_rdata | output | CTL_W (9) | Control word readback |
| mode_rdata | output | MODE_W (10) | Mode word readback |

## Verification
The bench sets each path's enable and disable bits both at once. A design in which the enable bit wins would open a path that should stay shut. Every mode is driven with line and software bytes together. A wrong case in the router would send echo traffic only one way, or let software bytes through in remote loopback. The bench also checks that a flush lasts one cycle and that the command bits read back as zero, so a level-held flush or a sticky command bit shows up. Finally, it disables the receive path in local loopback and changes the enables in the same cycle as a byte strobe. This exposes designs that bypass the enable for looped-back bytes or that act on a control word before it has been written.

// File: rtl/uart_mode_router_pkg.sv
package uart_mode_router_pkg;

   // control word bit positions (software decodes these)
   localparam int unsigned CB_RX_FLUSH = 0;
   localparam int unsigned CB_TX_FLUSH = 1;
   localparam int unsigned CB_RX_ON    = 2;
   localparam int unsigned CB_RX_OFF   = 3;
   localparam int unsigned CB_TX_ON    = 4;
   localparam int unsigned CB_TX_OFF   = 5;
   localparam int unsigned CB_TMO_RST  = 6;
   localparam int unsigned CB_BRK_GO   = 7;
   localparam int unsigned CB_BRK_END  = 8;
   localparam int unsigned CB_COUNT    = 9;

   // channel mode field location inside the mode word
   localparam int unsigned MODE_FIELD_LSB = 8;
   localparam int unsigned MODE_FIELD_W   = 2;

   typedef enum logic [MODE_FIELD_W-1:0] {
      CHAN_NORMAL = 2'd0,
      CHAN_ECHO   = 2'd1,
      CHAN_LLOOP  = 2'd2,
      CHAN_RLOOP  = 2'd3
   } chan_mode_e;

endpackage

// File: rtl/uart_ctl_word.sv
module uart_ctl_word
   import uart_mode_router_pkg::*;
#(
   parameter int unsigned CTL_W = CB_COUNT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr_i,
   input  logic [CTL_W-1:0] ctl_wdata_i,
   output logic [CTL_W-1:0] ctl_q_o,
   output logic             rx_en_o,
   output logic             tx_en_o,
   output logic             brk_o,
   output logic             rxq_flush_o,
   output logic             txq_flush_o
);

   localparam logic [CTL_W-1:0] CMD_MASK =
      CTL_W'((1 << CB_RX_FLUSH) | (1 << CB_TX_FLUSH));
   localparam logic [CTL_W-1:0] RESET_VAL =
      CTL_W'((1 << CB_RX_OFF) | (1 << CB_TX_OFF) | (1 << CB_BRK_END));

   generate
      if (CTL_W < CB_COUNT) begin : g_bad_ctl_w
         $error("uart_ctl_word: CTL_W too small for control bit map");
      end
   endgenerate

   logic [CTL_W-1:0] ctl_q;
   logic             rx_fl_q, tx_fl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= RESET_VAL;
         rx_fl_q <= 1'b0;
         tx_fl_q <= 1'b0;
      end else begin
         rx_fl_q <= ctl_wr_i & ctl_wdata_i[CB_RX_FLUSH];
         tx_fl_q <= ctl_wr_i & ctl_wdata_i[CB_TX_FLUSH];
         if (ctl_wr_i) begin
            ctl_q <= ctl_wdata_i & ~CMD_MASK;
         end
      end
   end

   assign ctl_q_o     = ctl_q;
   assign rx_en_o     = ctl_q[CB_RX_ON] & ~ctl_q[CB_RX_OFF];
   assign tx_en_o     = ctl_q[CB_TX_ON] & ~ctl_q[CB_TX_OFF];
   assign brk_o       = ctl_q[CB_BRK_GO] & ~ctl_q[CB_BRK_END];
   assign rxq_flush_o = rx_fl_q;
   assign txq_flush_o = tx_fl_q;

   assert_rx_flush_follows_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_i && ctl_wdata_i[CB_RX_FLUSH]) |=> rxq_flush_o);
   assert_rx_flush_only_on_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rxq_flush_o |-> $past(ctl_wr_i && ctl_wdata_i[CB_RX_FLUSH]));
   assert_tx_flush_only_on_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      txq_flush_o |-> $past(ctl_wr_i && ctl_wdata_i[CB_TX_FLUSH]));
   assert_rx_en_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_en_o) |-> $past(ctl_wr_i));
   assert_brk_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_o) |-> $past(ctl_wr_i && ctl_wdata_i[CB_BRK_GO]));

endmodule

// File: rtl/uart_mode_word.sv
module uart_mode_word
   import uart_mode_router_pkg::*;
#(
   parameter int unsigned MODE_W = MODE_FIELD_LSB + MODE_FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr_i,
   input  logic [MODE_W-1:0] mode_wdata_i,
   output logic [MODE_W-1:0] mode_q_o,
   output chan_mode_e        chan_o
);

   localparam int unsigned FIELD_MSB = MODE_FIELD_LSB + MODE_FIELD_W - 1;

   generate
      if (MODE_W <= FIELD_MSB) begin : g_bad_mode_w
         $error("uart_mode_word: MODE_W does not hold the channel mode field");
      end
   endgenerate

   logic [MODE_W-1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (mode_wr_i) begin
         mode_q <= mode_wdata_i;
      end
   end

   assign mode_q_o = mode_q;
   assign chan_o   = chan_mode_e'(mode_q[FIELD_MSB:MODE_FIELD_LSB]);

   assert_mode_only_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chan_o) |-> $past(mode_wr_i));

endmodule

// File: rtl/uart_byte_router.sv
module uart_byte_router
   import uart_mode_router_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  chan_mode_e        chan_i,
   input  logic              rx_en_i,
   input  logic              tx_en_i,
   input  logic              line_v_i,
   input  logic [DATA_W-1:0] line_d_i,
   input  logic              sw_v_i,
   input  logic [DATA_W-1:0] sw_d_i,
   output logic              rxq_push_o,
   output logic [DATA_W-1:0] rxq_data_o,
   output logic              txq_push_o,
   output logic [DATA_W-1:0] txq_data_o
);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data_w
         $error("uart_byte_router: DATA_W must be a serial character width");
      end
   endgenerate

   logic              rx_take, tx_take;
   logic [DATA_W-1:0] rx_pick, tx_pick;

   always_comb begin
      rx_take = 1'b0;
      tx_take = 1'b0;
      rx_pick = line_d_i;
      tx_pick = sw_d_i;
      unique case (chan_i)
         CHAN_NORMAL: begin
            rx_take = line_v_i;
            tx_take = sw_v_i;
         end
         CHAN_ECHO: begin
            rx_take = line_v_i;
            tx_take = line_v_i;
            tx_pick = line_d_i;
         end
         CHAN_LLOOP: begin
            rx_take = sw_v_i;
            rx_pick = sw_d_i;
         end
         CHAN_RLOOP: begin
            tx_take = line_v_i;
            tx_pick = line_d_i;
         end
         default: begin
            rx_take = 1'b0;
            tx_take = 1'b0;
         end
      endcase
      rx_take = rx_take & rx_en_i;
      tx_take = tx_take & tx_en_i;
   end

   generate
      if (OUT_REG) begin : g_reg_out
         logic              rxp_q, txp_q;
         logic [DATA_W-1:0] rxd_q, txd_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rxp_q <= 1'b0;
               txp_q <= 1'b0;
               rxd_q <= '0;
               txd_q <= '0;
            end else begin
               rxp_q <= rx_take;
               txp_q <= tx_take;
               if (rx_take) rxd_q <= rx_pick;
               if (tx_take) txd_q <= tx_pick;
            end
         end

         assign rxq_push_o = rxp_q;
         assign txq_push_o = txp_q;
         assign rxq_data_o = rxd_q;
         assign txq_data_o = txd_q;

         assert_rx_push_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rxq_push_o |-> $past(rx_en_i));
         assert_tx_push_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
            txq_push_o |-> $past(tx_en_i));
         assert_lloop_no_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(chan_i) == CHAN_LLOOP) |-> !txq_push_o);
         assert_rloop_no_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(chan_i) == CHAN_RLOOP) |-> !rxq_push_o);
         assert_echo_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_i == CHAN_ECHO && line_v_i && rx_en_i && tx_en_i)
               |=> (rxq_push_o && txq_push_o && rxq_data_o == txq_data_o));
      end else begin : g_comb_out
         assign rxq_push_o = rx_take;
         assign txq_push_o = tx_take;
         assign rxq_data_o = rx_pick;
         assign txq_data_o = tx_pick;

         assert_rx_push_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rxq_push_o |-> rx_en_i);
         assert_tx_push_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
            txq_push_o |-> tx_en_i);
         assert_lloop_no_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_i == CHAN_LLOOP) |-> !txq_push_o);
         assert_rloop_no_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_i == CHAN_RLOOP) |-> !rxq_push_o);
      end
   endgenerate

endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
   import uart_mode_router_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CTL_W   = CB_COUNT,
   parameter int unsigned MODE_W  = MODE_FIELD_LSB + MODE_FIELD_W,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              line_rx_valid,
   input  logic [DATA_W-1:0] line_rx_data,
   input  logic              sw_tx_valid,
   input  logic [DATA_W-1:0] sw_tx_data,
   output logic              rxq_push,
   output logic [DATA_W-1:0] rxq_data,
   output logic              txq_push,
   output logic [DATA_W-1:0] txq_data,
   output logic              rxq_flush,
   output logic              txq_flush,
   output logic              brk_req,
   output logic              rx_en,
   output logic              tx_en,
   output logic [CTL_W-1:0]  ctl_rdata,
   output logic [MODE_W-1:0] mode_rdata
);

   chan_mode_e chan;

   uart_ctl_word #(.CTL_W(CTL_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr_i    (ctl_wr),
      .ctl_wdata_i (ctl_wdata),
      .ctl_q_o     (ctl_rdata),
      .rx_en_o     (rx_en),
      .tx_en_o     (tx_en),
      .brk_o       (brk_req),
      .rxq_flush_o (rxq_flush),
      .txq_flush_o (txq_flush)
   );

   uart_mode_word #(.MODE_W(MODE_W)) u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_wr_i    (mode_wr),
      .mode_wdata_i (mode_wdata),
      .mode_q_o     (mode_rdata),
      .chan_o       (chan)
   );

   uart_byte_router #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_i     (chan),
      .rx_en_i    (rx_en),
      .tx_en_i    (tx_en),
      .line_v_i   (line_rx_valid),
      .line_d_i   (line_rx_data),
      .sw_v_i     (sw_tx_valid),
      .sw_d_i     (sw_tx_data),
      .rxq_push_o (rxq_push),
      .rxq_data_o (rxq_data),
      .txq_push_o (txq_push),
      .txq_data_o (txq_data)
   );

   assert_cmd_bits_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (ctl_rdata[CB_TX_FLUSH:CB_RX_FLUSH] == 2'b00));

endmodule

// File: tb/tb_uart_mode_router.sv
module tb_uart_mode_router;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [8:0] ctl_wdata = '0;
   logic       mode_wr = 1'b0;
   logic [9:0] mode_wdata = '0;
   logic       line_rx_valid = 1'b0;
   logic [7:0] line_rx_data = '0;
   logic       sw_tx_valid = 1'b0;
   logic [7:0] sw_tx_data = '0;
   logic       rxq_push, txq_push, rxq_flush, txq_flush, brk_req, rx_en, tx_en;
   logic [7:0] rxq_data, txq_data;
   logic [8:0] ctl_rdata;
   logic [9:0] mode_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   uart_mode_router dut (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .mode_wr(mode_wr), .mode_wdata(mode_wdata),
      .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data),
      .sw_tx_valid(sw_tx_valid), .sw_tx_data(sw_tx_data),
      .rxq_push(rxq_push), .rxq_data(rxq_data),
      .txq_push(txq_push), .txq_data(txq_data),
      .rxq_flush(rxq_flush), .txq_flush(txq_flush),
      .brk_req(brk_req), .rx_en(rx_en), .tx_en(tx_en),
      .ctl_rdata(ctl_rdata), .mode_rdata(mode_rdata)
   );

   typedef struct packed {
      logic [1:0] mode;
      logic       lv;
      logic [7:0] ld;
      logic       sv;
      logic [7:0] sd;
      logic       erp;
      logic [7:0] erd;
      logic       etp;
      logic [7:0] etd;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 1'b1, 8'hA1, 1'b1, 8'h3C, 1'b1, 8'hA1, 1'b1, 8'h3C},
      '{2'd0, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b1, 8'h5A, 1'b0, 8'h00},
      '{2'd0, 1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b1, 8'hFF},
      '{2'd1, 1'b1, 8'h77, 1'b1, 8'h99, 1'b1, 8'h77, 1'b1, 8'h77},
      '{2'd1, 1'b0, 8'h00, 1'b1, 8'h42, 1'b0, 8'h00, 1'b0, 8'h00},
      '{2'd2, 1'b1, 8'h11, 1'b1, 8'h22, 1'b1, 8'h22, 1'b0, 8'h00},
      '{2'd2, 1'b1, 8'h33, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00},
      '{2'd3, 1'b1, 8'h44, 1'b1, 8'h55, 1'b0, 8'h00, 1'b1, 8'h44},
      '{2'd3, 1'b0, 8'h00, 1'b1, 8'h66, 1'b0, 8'h00, 1'b0, 8'h00}
   };

   function automatic string req_of_mode(input logic [1:0] m);
      case (m)
         2'd0: return "R5";
         2'd1: return "R6";
         2'd2: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [8:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic wr_mode(input logic [1:0] m);
      mode_wr = 1'b1; mode_wdata = {m, 8'h00};
      @(negedge clk);
      mode_wr = 1'b0; mode_wdata = '0;
   endtask

   // drive one strobe cycle; on return the registered pushes are visible
   task automatic send(input logic lv, input logic [7:0] ld,
                       input logic sv, input logic [7:0] sd);
      line_rx_valid = lv; line_rx_data = ld;
      sw_tx_valid = sv; sw_tx_data = sd;
      @(negedge clk);
      line_rx_valid = 1'b0; sw_tx_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(ctl_rdata == 9'h128, "R1", "ctl readback", 32'(ctl_rdata), 32'h128);
      chk(mode_rdata == 10'h0, "R1", "mode readback", 32'(mode_rdata), 0);
      chk({rx_en, tx_en, brk_req} == 3'b000, "R1", "en/brk", 32'({rx_en, tx_en, brk_req}), 0);
      chk({rxq_push, txq_push, rxq_flush, txq_flush} == 4'b0, "R1", "strobes",
          32'({rxq_push, txq_push, rxq_flush, txq_flush}), 0);

      // R9 paths still disabled after reset: a byte must not pass
      send(1'b1, 8'hC3, 1'b1, 8'hC4);
      chk({rxq_push, txq_push} == 2'b00, "R9", "push while disabled after reset",
          32'({rxq_push, txq_push}), 0);

      // R2 enable and disable together: disable wins
      wr_ctl(9'h03C);
      chk({rx_en, tx_en} == 2'b00, "R2", "en+dis both set", 32'({rx_en, tx_en}), 0);
      wr_ctl(9'h004);
      chk({rx_en, tx_en} == 2'b10, "R2", "rx only enabled", 32'({rx_en, tx_en}), 32'b10);
      wr_ctl(9'h010);
      chk({rx_en, tx_en} == 2'b01, "R2", "tx only enabled", 32'({rx_en, tx_en}), 32'b01);

      // R4 break request
      wr_ctl(9'h080);
      chk(brk_req == 1'b1, "R4", "break start", 32'(brk_req), 1);
      wr_ctl(9'h180);
      chk(brk_req == 1'b0, "R4", "break stop dominates", 32'(brk_req), 0);
      wr_ctl(9'h100);
      chk(brk_req == 1'b0, "R4", "break idle", 32'(brk_req), 0);

      // R3 flush commands: pulse one cycle, read back zero
      ctl_wr = 1'b1; ctl_wdata = 9'h015;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_wdata = '0;
      chk(rxq_flush == 1'b1 && txq_flush == 1'b0, "R3", "rx flush pulse",
          32'({rxq_flush, txq_flush}), 32'b10);
      chk(ctl_rdata == 9'h014, "R3", "command bits read zero", 32'(ctl_rdata), 32'h014);
      @(negedge clk);
      chk(rxq_flush == 1'b0, "R3", "rx flush single cycle", 32'(rxq_flush), 0);
      wr_ctl(9'h016);
      chk(txq_flush == 1'b1 && rxq_flush == 1'b0, "R3", "tx flush pulse",
          32'({rxq_flush, txq_flush}), 32'b01);
      @(negedge clk);
      chk(txq_flush == 1'b0, "R3", "tx flush single cycle", 32'(txq_flush), 0);

      // table of routing vectors, both paths open (ctl = 0x014)
      for (int i = 0; i < NV; i++) begin
         wr_mode(VECS[i].mode);
         send(VECS[i].lv, VECS[i].ld, VECS[i].sv, VECS[i].sd);
         chk(rxq_push == VECS[i].erp, req_of_mode(VECS[i].mode), $sformatf("vec %0d rx push", i),
             32'(rxq_push), 32'(VECS[i].erp));
         if (VECS[i].erp)
            chk(rxq_data == VECS[i].erd, req_of_mode(VECS[i].mode), $sformatf("vec %0d rx data", i),
                32'(rxq_data), 32'(VECS[i].erd));
         chk(txq_push == VECS[i].etp, req_of_mode(VECS[i].mode), $sformatf("vec %0d tx push", i),
             32'(txq_push), 32'(VECS[i].etp));
         if (VECS[i].etp)
            chk(txq_data == VECS[i].etd, req_of_mode(VECS[i].mode), $sformatf("vec %0d tx data", i),
                32'(txq_data), 32'(VECS[i].etd));
         @(negedge clk);
         chk({rxq_push, txq_push} == 2'b00, "R5", $sformatf("vec %0d push lasts one cycle", i),
             32'({rxq_push, txq_push}), 0);
      end

      // R9 local loopback with receive disabled: software byte dropped
      wr_mode(2'd2);
      wr_ctl(9'h018);
      send(1'b0, 8'h00, 1'b1, 8'hB7);
      chk({rxq_push, txq_push} == 2'b00, "R9", "lloop rx disabled", 32'({rxq_push, txq_push}), 0);

      // R9 normal with transmit disabled: rx passes, tx blocked
      wr_mode(2'd0);
      wr_ctl(9'h024);
      send(1'b1, 8'h6D, 1'b1, 8'h6E);
      chk({rxq_push, txq_push} == 2'b10, "R9", "normal tx disabled", 32'({rxq_push, txq_push}), 32'b10);

      // R9 echo with transmit disabled: only the receive copy
      wr_mode(2'd1);
      send(1'b1, 8'h2B, 1'b0, 8'h00);
      chk({rxq_push, txq_push} == 2'b10 && rxq_data == 8'h2B, "R9", "echo tx disabled",
          32'({rxq_push, txq_push, rxq_data}), 32'h22B);

      // R10 byte in the same cycle as a disabling write uses old enables
      wr_mode(2'd0);
      wr_ctl(9'h014);
      ctl_wr = 1'b1; ctl_wdata = 9'h028;
      line_rx_valid = 1'b1; line_rx_data = 8'h5F;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_wdata = '0; line_rx_valid = 1'b0;
      chk(rxq_push == 1'b1 && rxq_data == 8'h5F, "R10", "same-cycle disable uses old enable",
          32'({rxq_push, rxq_data}), 32'h15F);
      send(1'b1, 8'h60, 1'b0, 8'h00);
      chk(rxq_push == 1'b0, "R10", "next byte sees disable", 32'(rxq_push), 0);

      // R10 enabling write with a same-cycle byte: byte still blocked
      ctl_wr = 1'b1; ctl_wdata = 9'h014;
      sw_tx_valid = 1'b1; sw_tx_data = 8'h81;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_wdata = '0; sw_tx_valid = 1'b0;
      chk(txq_push == 1'b0, "R10", "same-cycle enable not yet in force", 32'(txq_push), 0);

      finish_run();
   end

endmodule